// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Collector

This block gathers thirty-two peripheral interrupt request lines into one pending word and raises a single level interrupt towards a processor. Each request line passes through a synchroniser and an edge detector. A rising level marks the matching pending bit, and a falling level removes it. Peripheral number n feeds pending bit 31 − n, so low-numbered peripherals occupy the top of the word.

Software reaches the block over a plain register bus with an address, a write enable, write data, a read strobe and read data. The bus has four word registers. The pending register is cleared by writing ones. The force register replaces the whole pending word. The mask register holds one enable bit per source. The gated view is read-only and shows pending AND mask.

The output is driven by a two-state machine. In state IRQ_LOW the output is low. In state IRQ_HIGH the output is high. The machine takes transition RAISE (IRQ_LOW to IRQ_HIGH) when the gated word is nonzero. It takes transition DROP (IRQ_HIGH to IRQ_LOW) when the gated word is zero. Otherwise it stays where it is.

Top module: `irq_collector`

## Requirements
- R1: After reset the pending word and the mask word are 0, `cpu_irq` is low, and `rd_data` is 0.
- R2: Peripheral input `periph_req[n]` maps to pending bit 31 − n. A low-to-high change on that input sets the bit. The bit is visible to a read issued 4 clocks after the input changes, with 2 synchroniser stages.
- R3: A high-to-low change on `periph_req[n]` clears pending bit 31 − n. A steady level does not re-set a bit that software has cleared.
- R4: Offset 0x0 is the pending register. Writing it clears every pending bit whose write-data bit is 1 and leaves the bits written as 0 unchanged. Reading it returns the raw pending word.
- R5: Writing offset 0x4 (the force register) loads the whole pending word with the write data. Reading 0x4 returns the raw pending word.
- R6: Offset 0x8 is the mask register. It holds one enable bit per pending bit and is fully readable and writable.
- R7: Reading offset 0xC returns pending AND mask. Writes to 0xC change neither the pending word nor the mask word.
- R8: `cpu_irq` is high exactly when pending AND mask is nonzero. It follows one clock after the register update that causes the change.
- R9: When a source edge and a software write (to 0x0 or 0x4) act on the same pending bit in the same cycle, the source edge decides the bit.
- R10: Any address whose two low bits are not 00 is undefined. Reads of it return 0, and writes to it are ignored.
- R11: `rd_data` is captured at the clock edge that samples `rd_en` high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_req | input | 32 | Peripheral request levels, indexed by peripheral number |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| cpu_irq | output | 1 | Level interrupt to the processor |

## Verification
The bench raises and drops single peripheral lines at the bottom, middle and top of the index range. This tells a correct bit-reversed mapping apart from a straight one, and it separates edge capture from level following. Dense and sparse words are written through the clear-by-one, force and mask registers, so that a clear that also sets bits, or a force that merges instead of replacing, shows up in the read-back. Writes are also timed to land in the same cycle as a source edge on the same bit, for both rising and falling edges. These two cases separate source-first from software-first ordering. Finally, the gated view, the undefined offsets, and the one-clock lag of the interrupt output are probed just before and just after each mask change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned ADDR_W = 4;

    // Register select, taken from address bits [3:2]
    typedef enum logic [1:0] {
        SEL_PEND   = 2'd0,   // 0x0 clear-by-one pending
        SEL_FORCE  = 2'd1,   // 0x4 whole-word load
        SEL_MASK   = 2'd2,   // 0x8 enable bits
        SEL_GATED  = 2'd3    // 0xC pending & mask, read-only
    } reg_sel_e;

    typedef enum logic {
        IRQ_LOW  = 1'b0,
        IRQ_HIGH = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.hit = (a[1:0] == 2'b00);
        d.sel = reg_sel_e'(a[3:2]);
        return d;
    endfunction

endpackage

// File: rtl/irqc_src_sync.sv
module irqc_src_sync #(
    parameter int unsigned NSRC        = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] periph_req,
    output logic [NSRC-1:0] rise,
    output logic [NSRC-1:0] fall
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [NSRC-1:0] line;
    logic [NSRC-1:0] stage [SYNC_STAGES];
    logic [NSRC-1:0] seen;

    // Peripheral n drives source line NSRC-1-n (R2)
    for (genvar n = 0; n < NSRC; n++) begin : g_rev
        assign line[NSRC-1-n] = periph_req[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= '0;
            seen <= '0;
        end else begin
            stage[0] <= line;
            for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
            seen <= stage[LAST];
        end
    end

    assign rise = stage[LAST] & ~seen;
    assign fall = ~stage[LAST] & seen;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   rise,
    input  logic [NSRC-1:0]   fall,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSRC-1:0]   wr_data,
    output logic [NSRC-1:0]   pend,
    output logic [NSRC-1:0]   mask,
    output logic [NSRC-1:0]   rd_data
);

    reg_dec_t        dec;
    logic [NSRC-1:0] sw_pend;
    logic [NSRC-1:0] pend_nxt;
    logic [NSRC-1:0] rd_mux;

    assign dec = decode_addr(addr);

    // Software effect first, then source edges override it (R9)
    always_comb begin
        sw_pend = pend;
        if (wr_en && dec.hit) begin
            unique case (dec.sel)
                SEL_PEND:  sw_pend = pend & ~wr_data;
                SEL_FORCE: sw_pend = wr_data;
                default:   sw_pend = pend;
            endcase
        end
        pend_nxt = (sw_pend | rise) & ~fall;
    end

    always_comb begin
        rd_mux = '0;
        if (dec.hit) begin
            unique case (dec.sel)
                SEL_PEND, SEL_FORCE: rd_mux = pend;
                SEL_MASK:            rd_mux = mask;
                SEL_GATED:           rd_mux = pend & mask;
                default:             rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= '0;
            mask    <= '0;
            rd_data <= '0;
        end else begin
            pend <= pend_nxt;
            if (wr_en && dec.hit && dec.sel == SEL_MASK) mask <= wr_data;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend & $past(rise)) == $past(rise)));                        // R2
    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall) |=> ((pend & $past(fall)) == '0));                                 // R3
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h0) |=> ((pend & $past(wr_data & ~rise)) == '0));     // R4
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h8) |=> (mask == $past(wr_data)));                     // R6
    AST_GATED_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'hC) |=> (mask == $past(mask)));                        // R7
    AST_GATED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 4'hC) |=> (rd_data == $past(pend & mask)));              // R7
    AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[1:0] != 2'b00) |=> (rd_data == '0));                        // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));                                              // R11

endmodule

// File: rtl/irqc_out_fsm.sv
module irqc_out_fsm
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] mask,
    output logic            cpu_irq
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       any_live;

    assign any_live = |(pend & mask);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_LOW:  if (any_live)  state_d = IRQ_HIGH;   // RAISE
            IRQ_HIGH: if (!any_live) state_d = IRQ_LOW;    // DROP
            default:  state_d = IRQ_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_HIGH: cpu_irq = 1'b1;
            default:  cpu_irq = 1'b0;
        endcase
    end

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cpu_irq == $past(|(pend & mask))));                  // R8
    AST_IRQ_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask) == '0 && !cpu_irq) |=> !cpu_irq);               // R8

endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC        = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   periph_req,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSRC-1:0]   wr_data,
    output logic [NSRC-1:0]   rd_data,
    output logic              cpu_irq
);

    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] fall;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] mask;

    irqc_src_sync #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .periph_req (periph_req),
        .rise       (rise),
        .fall       (fall)
    );

    irqc_regs #(.NSRC(NSRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .fall    (fall),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .pend    (pend),
        .mask    (mask),
        .rd_data (rd_data)
    );

    irqc_out_fsm #(.NSRC(NSRC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .mask    (mask),
        .cpu_irq (cpu_irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!cpu_irq && rd_data == '0));                       // R1

endmodule

// File: tb/irq_collector_test.sv
module irq_collector_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] periph_req = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cpu_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_pend = '0;
    logic [31:0] m_mask = '0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_collector uut (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .cpu_irq(cpu_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'h0, 4'h4: return m_pend;
            4'h8:       return m_mask;
            4'hC:       return m_pend & m_mask;
            default:    return 32'h0;
        endcase
    endfunction

    // Drivers start just after a falling edge
    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, input string tag);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_src(input int n, input logic v);
        periph_req[n] = v;
        repeat (4) @(negedge clk);
        if (v) m_pend[31-n] = 1'b1;
        else   m_pend[31-n] = 1'b0;
    endtask

    // Monitor: read data is captured at the edge sampling rd_en (R11)
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " R11"}, rd_data, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq at reset", {31'b0, cpu_irq}, 32'h0);
        check("R1 rd_data at reset", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(4'h0, "R1 pending after reset");
        reg_read(4'h8, "R1 mask after reset");

        // R2 bit-reversed mapping
        set_src(0, 1'b1);
        reg_read(4'h0, "R2 periph0 -> bit31");
        set_src(5, 1'b1);
        set_src(31, 1'b1);
        reg_read(4'h0, "R2 periph5/31 -> bits26/0");
        check("R8 irq low while masked", {31'b0, cpu_irq}, 32'h0);

        // R6 and R8 timing
        reg_write(4'h8, 32'h8000_0000);
        m_mask = 32'h8000_0000;
        check("R8 irq not yet high", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        check("R8 irq high one clock later", {31'b0, cpu_irq}, 32'h1);
        reg_read(4'h8, "R6 mask readback");
        reg_read(4'hC, "R7 gated view");

        // R3 falling edge clears
        set_src(0, 1'b0);
        reg_read(4'h0, "R3 periph0 fall clears bit31");
        check("R8 irq low after clear", {31'b0, cpu_irq}, 32'h0);
        set_src(31, 1'b0);

        // R5 force register
        reg_write(4'h4, 32'hA5A5_0F0F);
        m_pend = 32'hA5A5_0F0F;
        reg_read(4'h0, "R5 force loads word");
        reg_read(4'h4, "R5 force read returns pending");

        // R4 clear by one
        reg_write(4'h0, 32'h8400_FF0F);
        m_pend = m_pend & ~32'h8400_FF0F;
        reg_read(4'h0, "R4 write-one clear");
        repeat (3) @(negedge clk);
        reg_read(4'h0, "R3 steady level does not re-set");

        // R7 writes to gated view ignored
        reg_write(4'h8, 32'h00FF_00F0);
        m_mask = 32'h00FF_00F0;
        reg_write(4'hC, 32'hFFFF_FFFF);
        reg_read(4'h0, "R7 write to 0xC leaves pending");
        reg_read(4'h8, "R7 write to 0xC leaves mask");
        reg_read(4'hC, "R7 gated after mask change");
        @(negedge clk);
        check("R8 irq tracks gated word", {31'b0, cpu_irq},
              {31'b0, |(m_pend & m_mask)});

        // R10 undefined offsets
        reg_write(4'h2, 32'hFFFF_FFFF);
        reg_write(4'h9, 32'h0000_0000);
        reg_read(4'h0, "R10 undefined write leaves pending");
        reg_read(4'h8, "R10 undefined write leaves mask");
        reg_read(4'h1, "R10 undefined read is zero");
        reg_read(4'hE, "R10 undefined read is zero");

        // R9 rising source edge beats a same-cycle force of zero
        periph_req[10] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_write(4'h4, 32'h0000_0000);
        m_pend = 32'h0020_0000;
        repeat (2) @(negedge clk);
        reg_read(4'h0, "R9 rise wins over force");

        // R9 falling source edge beats a same-cycle force of ones
        periph_req[10] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_write(4'h4, 32'hFFFF_FFFF);
        m_pend = 32'hFFDF_FFFF;
        repeat (2) @(negedge clk);
        reg_read(4'h0, "R9 fall wins over force");

        // R9 rising edge beats a same-cycle clear-by-one
        periph_req[20] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_write(4'h0, 32'h0000_0800);
        m_pend[11] = 1'b1;
        repeat (2) @(negedge clk);
        reg_read(4'h0, "R9 rise wins over clear");

        repeat (4) @(negedge clk);
        check("R11 all reads observed", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule